// File: doc/BRIEF.md
# Reloadable programmable clock divider

This block derives a peripheral clock from its own (parent) clock by an integer ratio. Software programs it through two word-wide registers on a simple bus with a byte address, a write strobe, write data and combinational read data. One register holds control bits: a per-clock reload-force request, a global reload trigger and an output enable. The other register holds a staged divide value that does not affect the running clock until it is reloaded.

A reload needs both the reload-force bit and the global trigger. When both become set, the staged value is captured. It is applied at the next boundary of the divided clock's period, so no phase is ever cut short. A captured value outside the legal set {4, 5, 6, 8} is dropped and the running ratio is kept. Software then clears the request and trigger bits, and that clear leaves the applied ratio in place. The enable gates the divided output. When it is cleared, the output finishes its current period and then stays low.

Top module: `reload_clk_div`

## Requirements
- R1: After reset the control register reads 0x0000_0000, the ratio register reads 0x0000_0800 (staged ratio 8 in bits 13:8), the active ratio is 8 and the divided output is low.
- R2: Every bit of the control register (byte address 0x0) and of the ratio register (byte address 0x4) reads back exactly the last value written to it; other addresses read zero.
- R3: With enable (control bit 17) set and an active ratio N, the output repeats a period of N parent cycles: high for floor(N/2) cycles, then low for the remaining cycles.
- R4: Writing the ratio register alone (staged value in bits 13:8) does not change the output period.
- R5: The staged ratio is captured for reload only when reload-force (control bit 1) and the global trigger (control bit 8) become set together; either bit alone has no effect on the period.
- R6: A captured ratio takes effect only at the end of a full period, so every high and low phase has the length of one ratio.
- R7: A captured ratio other than 4, 5, 6 or 8 (including 0) is discarded and the previous active ratio is kept.
- R8: A write that clears control bits 8:0 after a reload leaves the newly applied ratio in effect.
- R9: Clearing the enable lets the current high phase and low phase finish at full length, then holds the output low.
- R10: Setting the enable again restarts the output with a full high phase of the active ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; 0x0 control, 0x4 ratio |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| div_clk_o | output | 1 | Divided, gated clock output |

## Verification
A wrong active ratio appears on div_clk_o as a wrong high or low phase length within one period after the next reload boundary. The bench therefore measures phase lengths rather than single edges. A lost or spurious pending reload shows as a period that changes, or fails to change, by the second period after the control write. A broken gating state shows as either a truncated high phase at the moment of disable or an edge during the 40 cycles afterwards. Register corruption appears right away in the combinational readback.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int RATIO_W   = 6;
    localparam int RATIO_LSB = 8;
    localparam int FORCE_BIT = 1;
    localparam int TRIG_BIT  = 8;
    localparam int EN_SHIFT  = 16;
    localparam int EN_BIT    = FORCE_BIT + EN_SHIFT;

    typedef logic [RATIO_W-1:0] ratio_t;

    localparam ratio_t RATIO_RST = ratio_t'(8);

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_RATIO = 2'd1,
        SEL_NONE  = 2'd2
    } sel_e;

    typedef struct packed {
        logic   vld;
        ratio_t val;
    } pend_t;

    function automatic logic ratio_legal(input ratio_t r);
        return (r == ratio_t'(4)) || (r == ratio_t'(5)) ||
               (r == ratio_t'(6)) || (r == ratio_t'(8));
    endfunction

    function automatic ratio_t high_len(input ratio_t r);
        return r >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              force_o,
    output logic              trig_o,
    output logic              en_o,
    output ratio_t            staged_o
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [DATA_W-1:0] RATIO_REG_RST =
        DATA_W'(RATIO_RST) << RATIO_LSB;

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ratio_q;
    logic [WIDX_W-1:0] widx;
    sel_e              sel;

    assign widx = bus_addr[ADDR_W-1:2];

    always_comb begin
        if (widx == WIDX_W'(0))      sel = SEL_CTRL;
        else if (widx == WIDX_W'(1)) sel = SEL_RATIO;
        else                         sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ratio_q <= RATIO_REG_RST;
        end else if (bus_we) begin
            if (sel == SEL_CTRL)  ctrl_q  <= bus_wdata;
            if (sel == SEL_RATIO) ratio_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  bus_rdata = ctrl_q;
            SEL_RATIO: bus_rdata = ratio_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign force_o  = ctrl_q[FORCE_BIT];
    assign trig_o   = ctrl_q[TRIG_BIT];
    assign en_o     = ctrl_q[EN_BIT];
    assign staged_o = ratio_q[RATIO_LSB +: RATIO_W];

    assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && (sel == SEL_CTRL)) |-> (ctrl_q == $past(bus_wdata)));

    assert_ratio_readback_R2: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && (sel == SEL_RATIO)) |-> (ratio_q == $past(bus_wdata)));

endmodule

// File: rtl/clkdiv_reload.sv
module clkdiv_reload
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   force_i,
    input  logic   trig_i,
    input  ratio_t staged_i,
    input  logic   take_i,
    output pend_t  pend_o
);

    logic  arm;
    logic  arm_q;
    pend_t pend_q;

    assign arm = force_i && trig_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            arm_q <= arm;
            if (arm && !arm_q) begin
                pend_q.vld <= 1'b1;
                pend_q.val <= staged_i;
            end else if (take_i) begin
                pend_q.vld <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

    assert_pend_needs_both_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q.vld) |-> $past(force_i && trig_i));

endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_i,
    input  pend_t  pend_i,
    output logic   take_o,
    output logic   clk_o
);

    ratio_t act_q, act_n;
    ratio_t cnt_q, cnt_n;
    logic   run_q, run_n;
    logic   out_q, out_n;
    logic   at_edge;

    assign at_edge = !run_q || (cnt_q == act_q - ratio_t'(1));

    always_comb begin
        act_n = act_q;
        run_n = run_q;
        cnt_n = cnt_q + ratio_t'(1);
        if (at_edge) begin
            cnt_n = '0;
            run_n = en_i;
            if (pend_i.vld && ratio_legal(pend_i.val))
                act_n = pend_i.val;
        end
        out_n = run_n && (cnt_n < high_len(act_n));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= RATIO_RST;
            cnt_q <= '0;
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            act_q <= act_n;
            cnt_q <= cnt_n;
            run_q <= run_n;
            out_q <= out_n;
        end
    end

    assign take_o = at_edge && pend_i.vld;
    assign clk_o  = out_q;

    assert_active_legal_R7: assert property (@(posedge clk) disable iff (rst)
        ratio_legal(act_q));

    assert_ratio_change_at_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (act_q != $past(act_q)) |-> $past(at_edge));

    assert_rise_at_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> $past(at_edge));

    assert_stop_at_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> ($past(at_edge) && !$past(en_i)));

    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < act_q));

endmodule

// File: rtl/reload_clk_div.sv
module reload_clk_div
    import clkdiv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              div_clk_o
);

    logic   force_b;
    logic   trig_b;
    logic   en_b;
    ratio_t staged;
    pend_t  pend;
    logic   take;

    clkdiv_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .force_o  (force_b),
        .trig_o   (trig_b),
        .en_o     (en_b),
        .staged_o (staged)
    );

    clkdiv_reload reload_i (
        .clk     (clk),
        .rst     (rst),
        .force_i (force_b),
        .trig_i  (trig_b),
        .staged_i(staged),
        .take_i  (take),
        .pend_o  (pend)
    );

    clkdiv_gen gen_i (
        .clk   (clk),
        .rst   (rst),
        .en_i  (en_b),
        .pend_i(pend),
        .take_o(take),
        .clk_o (div_clk_o)
    );

    assert_low_in_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !div_clk_o);

endmodule

// File: tb/reload_clk_div_tb_top.sv
module reload_clk_div_tb_top;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int VEC_N  = 8;

    localparam int REQ [VEC_N] = '{4, 5, 6, 8, 3, 0, 7, 5};
    localparam int EHI [VEC_N] = '{2, 2, 3, 4, 4, 4, 4, 2};
    localparam int ELO [VEC_N] = '{2, 3, 3, 4, 4, 4, 4, 3};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              div_clk_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    reload_clk_div #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .div_clk_o(div_clk_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_rise();
        logic prev;
        @(negedge clk);
        prev = div_clk_o;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_clk_o && !prev) return;
            prev = div_clk_o;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        hi = 1;
        lo = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!div_clk_o) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_clk_o) break;
            lo++;
        end
    endtask

    task automatic reload(input int r);
        wr(4'h4, DATA_W'(r) << 8);
        wr(4'h0, 32'h0002_0102);
        repeat (20) @(negedge clk);
        wr(4'h0, 32'h0002_0000);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        int hi, lo;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(4'h0, d);
        check(d == 32'h0, "R1 ctrl reset", d, 32'h0);
        rd(4'h4, d);
        check(d == 32'h0000_0800, "R1 ratio reset", d, 32'h800);
        check(div_clk_o == 1'b0, "R1 output low", div_clk_o, 0);

        // R2: full-word readback and unmapped address
        wr(4'h0, 32'h5A5A_0055);
        rd(4'h0, d);
        check(d == 32'h5A5A_0055, "R2 ctrl readback", d, 32'h5A5A_0055);
        wr(4'h4, 32'h1234_5678);
        rd(4'h4, d);
        check(d == 32'h1234_5678, "R2 ratio readback", d, 32'h1234_5678);
        rd(4'h8, d);
        check(d == 32'h0, "R2 unmapped reads zero", d, 0);
        wr(4'h4, 32'h0000_0800);
        wr(4'h0, 32'h0002_0000);

        // R1 R3: default ratio 8 when enabled
        measure(hi, lo);
        check(hi == 4 && lo == 4, "R1 R3 default ratio 8", hi * 100 + lo, 404);

        // R3 R5 R6 R7 R8: vector table
        for (int v = 0; v < VEC_N; v++) begin
            reload(REQ[v]);
            rd(4'h0, d);
            check(d == 32'h0002_0000, "R8 ctrl after clear", d, 32'h0002_0000);
            measure(hi, lo);
            check(hi == EHI[v], "R3 R6 R7 R8 high phase", hi, EHI[v]);
            check(lo == ELO[v], "R3 R6 R7 R8 low phase", lo, ELO[v]);
        end

        // R4: staged write alone, active ratio stays 5
        wr(4'h4, 32'h0000_0400);
        repeat (20) @(negedge clk);
        measure(hi, lo);
        check(hi == 2 && lo == 3, "R4 staged only", hi * 100 + lo, 203);

        // R5: trigger alone
        wr(4'h0, 32'h0002_0100);
        repeat (20) @(negedge clk);
        wr(4'h0, 32'h0002_0000);
        measure(hi, lo);
        check(hi == 2 && lo == 3, "R5 trigger alone", hi * 100 + lo, 203);

        // R5: force alone
        wr(4'h0, 32'h0002_0002);
        repeat (20) @(negedge clk);
        wr(4'h0, 32'h0002_0000);
        measure(hi, lo);
        check(hi == 2 && lo == 3, "R5 force alone", hi * 100 + lo, 203);

        // R9: disable during the high phase
        wait_rise();
        bus_addr  = 4'h0;
        bus_wdata = 32'h0;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        hi = 1 + (div_clk_o ? 1 : 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!div_clk_o) break;
            hi++;
        end
        check(hi == 2, "R9 high phase not cut", hi, 2);
        lo = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (div_clk_o) lo++;
        end
        check(lo == 0, "R9 held low when gated", lo, 0);

        // R10: re-enable
        wr(4'h0, 32'h0002_0000);
        measure(hi, lo);
        check(hi == 2 && lo == 3, "R10 restart full phases", hi * 100 + lo, 203);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule